// File: doc/BRIEF.md
# Elapsed-Time Counter with Alarm Compare

This block keeps a free-running binary tick count that advances once per pulse of a 32768 Hz enable input. At that rate the whole-second value is the count with its fifteen lowest bits dropped. Software reaches the count through a narrow synchronous register port, one 16-bit halfword at a time. It can also load any halfword to set the time.

A second value of the same width holds an alarm time. On the tick that brings the count to exactly that value, a sticky status flag is raised. Software acknowledges the flag by writing a one to its bit. An interrupt line shows the flag gated by an enable bit in a control register.

The count is read live, with no snapshot. A carry that ripples between halfwords while software reads them therefore shows up as a difference between two successive read passes. It is never hidden inside a single pass. Software reads all halfwords twice and retries until both passes agree.

Top module: `elapsed_alarm_timer`

## Requirements
- R1: After reset the count halfwords, the alarm halfwords, the status register (0x3E) and the control register (0x3C) all read 0, and `irq` is low.
- R2: Each cycle with `tick` high adds one to the count. With `tick` low and no write, the count holds.
- R3: Count halfword k sits at byte address 2k: 0x00 holds bits [15:0], 0x02 holds [31:16] and 0x04 holds [47:32]. Seconds bit 0 is therefore bit 15 of address 0x00.
- R4: A write to a count halfword replaces only those 16 bits and leaves the others as they were. If `tick` is high in the same cycle, the written halfword takes the written data and the other halfwords take their incremented value. Later ticks count on from the new value.
- R5: A carry crosses halfword boundaries in a single tick. If that tick falls between two read passes, the passes return different values.
- R6: Alarm halfword k sits at byte address 0x08 + 2k and reads back what was written.
- R7: Status bit 0 at 0x3E is set on a cycle with `tick` high when the incremented count equals the alarm value. It stays set after the count moves past that value. A write that makes the count equal the alarm value without a tick does not set it.
- R8: Writing 1 to bit 0 of 0x3E clears the flag, and writing 0 there has no effect. If a match and a clear fall in the same cycle, the flag ends up set.
- R9: `irq` is high exactly when the flag is set and bit 0 of the control register at 0x3C is 1.
- R10: Addresses 0x06 and 0x0E read 0, and writes to them change no other register.
- R11: A tick applied to an all-ones count wraps it to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle count enable at 32768 Hz |
| bus_addr | input | 6 | Byte address of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from the address |
| irq | output | 1 | Alarm interrupt, flag AND enable |

## Verification
The bench builds the block with its default parameters: three 16-bit halfwords, which gives a 48-bit count. Real time could never carry the count across a halfword boundary within a short run. Instead, the bench loads values just below those boundaries, and also the all-ones value, so that a single tick reaches the carry, the wrap and the torn-read case. Placing the alarm value a few ticks ahead brings the match, the sticky hold after the count moves past it, and the collision of a match with a clear into the same short run.

// File: rtl/eat_pkg.sv
package eat_pkg;
    localparam int unsigned ADDR_W    = 6;
    localparam logic [ADDR_W-1:0] CMP_BASE  = 6'h08;
    localparam logic [ADDR_W-1:0] CTRL_ADDR = 6'h3C;
    localparam logic [ADDR_W-1:0] STAT_ADDR = 6'h3E;
    localparam int unsigned FLAG_BIT  = 0;
    localparam int unsigned EN_BIT    = 0;
endpackage

// File: rtl/eat_count.sv
module eat_count #(
    parameter int unsigned HALVES = 3,
    parameter int unsigned HW     = 16,
    localparam int unsigned CNT_W = HALVES * HW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [HALVES-1:0] wr_sel,
    input  logic [HW-1:0]     wdata,
    output logic [CNT_W-1:0]  cnt_q,
    output logic [CNT_W-1:0]  cnt_nx
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
        for (int i = 0; i < int'(HALVES); i++) begin
            if (wr_sel[i]) begin
                st_d.cnt[i*HW +: HW] = wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_q  = st_q.cnt;
    assign cnt_nx = st_d.cnt;

    // R2
    inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (wr_sel == '0)) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

    // R2
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && (wr_sel == '0)) |=> $stable(cnt_q));
endmodule

// File: rtl/eat_alarm.sv
module eat_alarm #(
    parameter int unsigned HALVES = 3,
    parameter int unsigned HW     = 16,
    localparam int unsigned CNT_W = HALVES * HW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [CNT_W-1:0]  cnt_nx,
    input  logic [HALVES-1:0] wr_sel,
    input  logic [HW-1:0]     wdata,
    input  logic              flag_clr,
    input  logic              en_wr,
    input  logic              en_val,
    output logic [CNT_W-1:0]  cmp_q,
    output logic              flag_q,
    output logic              en_q
);
    typedef struct packed {
        logic [CNT_W-1:0] cmp;
        logic             flag;
        logic             en;
    } alm_st_t;

    alm_st_t st_d, st_q;
    logic    hit;

    always_comb begin
        st_d = st_q;
        hit  = tick && (cnt_nx == st_q.cmp);
        for (int i = 0; i < int'(HALVES); i++) begin
            if (wr_sel[i]) begin
                st_d.cmp[i*HW +: HW] = wdata;
            end
        end
        if (hit) begin
            st_d.flag = 1'b1;
        end else if (flag_clr) begin
            st_d.flag = 1'b0;
        end
        if (en_wr) begin
            st_d.en = en_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmp_q  = st_q.cmp;
    assign flag_q = st_q.flag;
    assign en_q   = st_q.en;

    // R7
    match_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (cnt_nx == cmp_q)) |=> flag_q);

    // R7
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !flag_clr) |=> flag_q);

    // R8
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !(tick && (cnt_nx == cmp_q))) |=> !flag_q);
endmodule

// File: rtl/eat_readback.sv
module eat_readback
    import eat_pkg::*;
#(
    parameter int unsigned HALVES = 3,
    parameter int unsigned HW     = 16,
    localparam int unsigned CNT_W = HALVES * HW
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [CNT_W-1:0]  cmp,
    input  logic              flag,
    input  logic              en,
    output logic [HW-1:0]     rdata
);
    always_comb begin
        rdata = '0;
        for (int i = 0; i < int'(HALVES); i++) begin
            if (addr == ADDR_W'(2 * i)) begin
                rdata = cnt[i*HW +: HW];
            end
            if (addr == CMP_BASE + ADDR_W'(2 * i)) begin
                rdata = cmp[i*HW +: HW];
            end
        end
        if (addr == STAT_ADDR) begin
            rdata[FLAG_BIT] = flag;
        end
        if (addr == CTRL_ADDR) begin
            rdata[EN_BIT] = en;
        end
    end
endmodule

// File: rtl/elapsed_alarm_timer.sv
module elapsed_alarm_timer
    import eat_pkg::*;
#(
    parameter int unsigned HALVES = 3,
    parameter int unsigned HW     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [HW-1:0]     bus_wdata,
    output logic [HW-1:0]     bus_rdata,
    output logic              irq
);
    localparam int unsigned CNT_W = HALVES * HW;

    logic [HALVES-1:0] cnt_sel;
    logic [HALVES-1:0] cmp_sel;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  cnt_nx;
    logic [CNT_W-1:0]  cmp_q;
    logic              flag_q;
    logic              en_q;
    logic              stat_clr;
    logic              ctrl_wr;

    for (genvar i = 0; i < int'(HALVES); i++) begin : g_dec
        assign cnt_sel[i] = bus_we && (bus_addr == ADDR_W'(2 * i));
        assign cmp_sel[i] = bus_we && (bus_addr == CMP_BASE + ADDR_W'(2 * i));
    end

    assign stat_clr = bus_we && (bus_addr == STAT_ADDR) && bus_wdata[FLAG_BIT];
    assign ctrl_wr  = bus_we && (bus_addr == CTRL_ADDR);

    eat_count #(.HALVES(HALVES), .HW(HW)) u_count (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .wr_sel (cnt_sel),
        .wdata  (bus_wdata),
        .cnt_q  (cnt_q),
        .cnt_nx (cnt_nx)
    );

    eat_alarm #(.HALVES(HALVES), .HW(HW)) u_alarm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .cnt_nx   (cnt_nx),
        .wr_sel   (cmp_sel),
        .wdata    (bus_wdata),
        .flag_clr (stat_clr),
        .en_wr    (ctrl_wr),
        .en_val   (bus_wdata[EN_BIT]),
        .cmp_q    (cmp_q),
        .flag_q   (flag_q),
        .en_q     (en_q)
    );

    eat_readback #(.HALVES(HALVES), .HW(HW)) u_rb (
        .addr  (bus_addr),
        .cnt   (cnt_q),
        .cmp   (cmp_q),
        .flag  (flag_q),
        .en    (en_q),
        .rdata (bus_rdata)
    );

    assign irq = flag_q & en_q;

    // R9
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q || !flag_q) |-> !irq);
endmodule

// File: tb/elapsed_alarm_timer_test.sv
module elapsed_alarm_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    elapsed_alarm_timer uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    typedef struct packed {
        logic        rd;
        logic [5:0]  a;
        logic [15:0] v;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 6'h00, 16'h1234}, '{1'b0, 6'h02, 16'h5678}, '{1'b0, 6'h04, 16'h9ABC},
        '{1'b0, 6'h08, 16'h1111}, '{1'b0, 6'h0A, 16'h2222}, '{1'b0, 6'h0C, 16'h3333},
        '{1'b1, 6'h00, 16'h1234}, '{1'b1, 6'h02, 16'h5678}, '{1'b1, 6'h04, 16'h9ABC},
        '{1'b1, 6'h08, 16'h1111}, '{1'b1, 6'h0A, 16'h2222}, '{1'b1, 6'h0C, 16'h3333},
        '{1'b0, 6'h06, 16'hFFFF}, '{1'b1, 6'h06, 16'h0000}, '{1'b1, 6'h00, 16'h1234},
        '{1'b0, 6'h0E, 16'hFFFF}, '{1'b1, 6'h0E, 16'h0000}, '{1'b1, 6'h0C, 16'h3333}
    };

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic set_cnt(input logic [15:0] h, input logic [15:0] m, input logic [15:0] l);
        wr(6'h00, l); wr(6'h02, m); wr(6'h04, h);
    endtask

    task automatic expect_cnt(input string tag, input logic [15:0] h,
                              input logic [15:0] m, input logic [15:0] l);
        logic [15:0] r;
        rd(6'h00, r); check({tag, " low"}, r, l);
        rd(6'h02, r); check({tag, " mid"}, r, m);
        rd(6'h04, r); check({tag, " high"}, r, h);
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] r;
        logic [15:0] p1 [3];
        logic [15:0] p2 [3];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        expect_cnt("R1 count", 16'h0, 16'h0, 16'h0);
        rd(6'h08, r); check("R1 alarm low", r, 16'h0);
        rd(6'h0C, r); check("R1 alarm high", r, 16'h0);
        rd(6'h3E, r); check("R1 status", r, 16'h0);
        rd(6'h3C, r); check("R1 control", r, 16'h0);
        check("R1 irq", {15'b0, irq}, 16'h0);

        // R3 R6 R10 vector table
        for (int i = 0; i < NV; i++) begin
            if (VEC[i].rd) begin
                rd(VEC[i].a, r);
                check($sformatf("R3/R6/R10 table row %0d", i), r, VEC[i].v);
            end else begin
                wr(VEC[i].a, VEC[i].v);
            end
        end

        // R2 increment and hold
        set_cnt(16'h0, 16'h0, 16'h0);
        ticks(5);
        expect_cnt("R2 five ticks", 16'h0, 16'h0, 16'h0005);
        repeat (10) @(negedge clk);
        expect_cnt("R2 hold", 16'h0, 16'h0, 16'h0005);

        // R3 seconds bit 0 is bit 15 of low halfword
        set_cnt(16'h0, 16'h0, 16'h7FFF);
        ticks(1);
        expect_cnt("R3 seconds bit", 16'h0, 16'h0, 16'h8000);

        // R4 partial write
        wr(6'h02, 16'hABCD);
        expect_cnt("R4 mid write", 16'h0, 16'hABCD, 16'h8000);
        ticks(1);
        expect_cnt("R4 count on", 16'h0, 16'hABCD, 16'h8001);
        @(negedge clk);
        tick = 1'b1; bus_addr = 6'h02; bus_we = 1'b1; bus_wdata = 16'h0042;
        @(negedge clk);
        tick = 1'b0; bus_we = 1'b0;
        expect_cnt("R4 write with tick", 16'h0, 16'h0042, 16'h8002);

        // R5 carry across halfwords and torn read
        set_cnt(16'h0001, 16'hFFFF, 16'hFFFF);
        rd(6'h00, p1[0]); rd(6'h02, p1[1]); rd(6'h04, p1[2]);
        ticks(1);
        rd(6'h00, p2[0]); rd(6'h02, p2[1]); rd(6'h04, p2[2]);
        check("R5 passes differ", {15'b0, (p1[0] != p2[0] || p1[1] != p2[1] || p1[2] != p2[2])}, 16'h1);
        expect_cnt("R5 carry", 16'h0002, 16'h0, 16'h0);

        // R11 wrap
        set_cnt(16'hFFFF, 16'hFFFF, 16'hFFFF);
        ticks(1);
        expect_cnt("R11 wrap", 16'h0, 16'h0, 16'h0);

        // R7 alarm match and sticky
        wr(6'h08, 16'h0010); wr(6'h0A, 16'h0); wr(6'h0C, 16'h0);
        set_cnt(16'h0, 16'h0, 16'h000E);
        wr(6'h3E, 16'h0001);
        rd(6'h3E, r); check("R7 cleared before", r, 16'h0);
        ticks(1);
        rd(6'h3E, r); check("R7 no early set", r, 16'h0);
        ticks(1);
        rd(6'h3E, r); check("R7 set on match", r, 16'h1);
        ticks(1);
        rd(6'h3E, r); check("R7 sticky past", r, 16'h1);
        check("R9 irq masked", {15'b0, irq}, 16'h0);

        // R9 enable gating
        wr(6'h3C, 16'h0001);
        check("R9 irq on", {15'b0, irq}, 16'h1);
        wr(6'h3C, 16'h0000);
        check("R9 irq off", {15'b0, irq}, 16'h0);
        wr(6'h3C, 16'h0001);

        // R8 write-one-to-clear
        wr(6'h3E, 16'h0000);
        rd(6'h3E, r); check("R8 write zero keeps", r, 16'h1);
        wr(6'h3E, 16'h0001);
        rd(6'h3E, r); check("R8 write one clears", r, 16'h0);
        check("R8 irq after clear", {15'b0, irq}, 16'h0);

        // R7 write alone cannot raise flag
        wr(6'h00, 16'h0010);
        rd(6'h3E, r); check("R7 write no set", r, 16'h0);

        // R8 set wins over clear
        set_cnt(16'h0, 16'h0, 16'h000F);
        @(negedge clk);
        tick = 1'b1; bus_addr = 6'h3E; bus_we = 1'b1; bus_wdata = 16'h0001;
        @(negedge clk);
        tick = 1'b0; bus_we = 1'b0;
        rd(6'h3E, r); check("R8 set over clear", r, 16'h1);
        check("R9 irq with enable", {15'b0, irq}, 16'h1);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule